// File: doc/BRIEF.md
# Auto-Reload Countdown Timer with Level and Pulse Interrupts

This block is an 8-bit down-counter that measures out repeating periods for a host. The counter takes its steps from one of four tick enables produced by a shared clock divider. Index 0 is the fastest source at 4096 Hz, then 64 Hz, then 1 Hz, and index 3 is the slowest at one tick per minute. When the count reaches the end of a period, the counter loads the host's value again and raises a sticky flag.

An active-low interrupt request reports each period end in one of two ways. In level mode it follows the flag. In pulse mode it gives a low pulse whose length is measured in ticks of an 8192 Hz reference enable. The current count is always visible so that the host can read it back.

The host works through separate write strobes: one for the run bit, one for the source select, one for the reload value, and one for a status word. The status word carries the flag clear bit, the interrupt enable and the interrupt mode. The divider that makes the tick enables lies outside this block.

Top module: `tmr_countdown`

## Requirements
- R1: After reset the count is 0, the flag is 0, `irq_n` is 1, the timer is stopped, the interrupt enable is 0, level mode is selected, and the source select is 3. With the select left at its reset value, only ticks on `src_tick[3]` move the count.
- R2: Only ticks on `src_tick[i]` with i equal to the stored source select change the count. Ticks on the other three bits have no effect.
- R3: While running with a reload value n > 0, each selected tick takes the count one step down. A tick at count 1 loads n again. For n = 3 the count therefore runs 3, 2, 1, 3, 2, 1 and so on, and one period lasts n ticks.
- R4: While the reload value is 0, ticks leave the count unchanged and never set the flag.
- R5: The flag becomes 1 on the tick that ends a period. A status write with flag bit 0 clears it. A status write with flag bit 1 leaves it unchanged. A period end and a clearing write in the same cycle leave the flag at 1.
- R6: In level mode (status mode bit 0), `irq_n` is 0 exactly when the flag is 1 and the interrupt enable is 1.
- R7: In pulse mode (status mode bit 1) with the interrupt enable set, `irq_n` goes to 0 in the same cycle that the flag is set. It returns to 1 after the pulse width, whatever the flag then holds. With the interrupt enable at 0, `irq_n` stays at 1.
- R8: The pulse width, counted in `ref_tick` pulses from the period end, depends on the source and on n:
  - source 0 with n = 1: 1 pulse
  - source 0 with n > 1: 2 pulses
  - source 1 with n = 1: 64 pulses
  - source 1 with n > 1: 128 pulses
  - sources 2 and 3, any n: 128 pulses
- R9: A reload write while stopped also loads the count at once. A reload write while running leaves the count alone and is used from the next reload onwards.
- R10: While stopped, the count does not change except through a reload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Tick enables, one per source; index 0 is the fastest |
| ref_tick | input | 1 | 8192 Hz reference enable used to time pulses |
| run_we | input | 1 | Write strobe for the run bit |
| run_in | input | 1 | New run bit value |
| sel_we | input | 1 | Write strobe for the source select |
| sel_in | input | 2 | New source select value |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_in | input | 8 | New reload value n |
| stat_we | input | 1 | Write strobe for the status word |
| stat_flag_in | input | 1 | Flag write bit: 0 clears, 1 keeps |
| stat_ie_in | input | 1 | New interrupt enable |
| stat_mode_in | input | 1 | New interrupt mode: 0 level, 1 pulse |
| irq_n | output | 1 | Active-low interrupt request |
| flag | output | 1 | Sticky period-end flag |
| count | output | 8 | Current count value |

## Verification
A vector table runs the counter with each source and several reload values, including 0, 1, 2 and values well above the tick count, for tick counts below, at and past one period. This shows whether stepping, the reload point and the flag are placed correctly. Ticks on the sources that are not selected are mixed in between, so that a wrong decode shows up as a changed count. Pulse widths are measured for each source with n = 1 and with n > 1, which separates the five width classes. Further directed cases cover a reload write while running, the collision of a flag clear with a period end, and the effect of the interrupt enable in both modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic {
      IRQ_LEVEL = 1'b0,
      IRQ_PULSE = 1'b1
   } irq_mode_e;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
   parameter int NUM_SRC = 4,
   localparam int SEL_W = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);

   logic [NUM_SRC-1:0] hit;

   // One compare per source; the selected source passes its tick through.
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
   end

   assign tick = |hit;

endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_in,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] reload,
   output logic             period_end
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] reload_q;
   logic             step;

   assign step       = run && tick && (reload_q != ZERO);
   assign period_end = step && (count_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= ZERO;
         reload_q <= ZERO;
      end else begin
         if (reload_we) begin
            reload_q <= reload_in;
         end
         if (reload_we && !run) begin
            count_q <= reload_in;
         end else if (step) begin
            // A count of 1 ends the period; a count of 0 only primes the counter.
            if (count_q <= ONE) begin
               count_q <= reload_q;
            end else begin
               count_q <= count_q - ONE;
            end
         end
      end
   end

   assign count  = count_q;
   assign reload = reload_q;

endmodule

// File: rtl/tmr_pulse_gen.sv
module tmr_pulse_gen #(
   parameter int PW_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PW_W-1:0] width,
   input  logic            ref_tick,
   output logic            active
);

   logic [PW_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start) begin
         left_q <= width;
      end else if (ref_tick && (left_q != '0)) begin
         left_q <= left_q - PW_W'(1);
      end
   end

   assign active = (left_q != '0);

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
   import tmr_pkg::*;
#(
   parameter int NUM_SRC      = 4,
   parameter int CNT_W        = 8,
   parameter int PW_FAST_ONE  = 1,
   parameter int PW_FAST_MANY = 2,
   parameter int PW_MID_ONE   = 64,
   parameter int PW_MID_MANY  = 128,
   parameter int PW_SLOW      = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               ref_tick,
   input  logic               run_we,
   input  logic               run_in,
   input  logic               sel_we,
   input  logic [1:0]         sel_in,
   input  logic               reload_we,
   input  logic [CNT_W-1:0]   reload_in,
   input  logic               stat_we,
   input  logic               stat_flag_in,
   input  logic               stat_ie_in,
   input  logic               stat_mode_in,
   output logic               irq_n,
   output logic               flag,
   output logic [CNT_W-1:0]   count
);

   localparam int SEL_W  = $clog2(NUM_SRC);
   localparam int PW_MAX = (PW_SLOW > PW_MID_MANY) ? PW_SLOW : PW_MID_MANY;
   localparam int PW_W   = $clog2(PW_MAX + 1);

   // Elaboration-time checks on the parameter set.
   if (NUM_SRC != 4) begin : g_bad_src
      $error("tmr_countdown: NUM_SRC must be 4");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_countdown: CNT_W too small");
   end
   if (PW_FAST_ONE < 1 || PW_FAST_MANY < PW_FAST_ONE) begin : g_bad_fast
      $error("tmr_countdown: fast pulse widths invalid");
   end
   if (PW_MID_ONE < 1 || PW_MID_MANY < PW_MID_ONE || PW_SLOW < 1) begin : g_bad_slow
      $error("tmr_countdown: mid/slow pulse widths invalid");
   end

   logic             run_q;
   logic [SEL_W-1:0] sel_q;
   logic             ie_q;
   irq_mode_e        mode_q;
   logic             flag_q;
   logic             tick;
   logic [CNT_W-1:0] reload_q;
   logic             period_end;
   logic [PW_W-1:0]  width;
   logic             pulse_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sel_q  <= SEL_W'(NUM_SRC - 1);
         ie_q   <= 1'b0;
         mode_q <= IRQ_LEVEL;
         flag_q <= 1'b0;
      end else begin
         if (run_we) begin
            run_q <= run_in;
         end
         if (sel_we) begin
            sel_q <= sel_in;
         end
         if (stat_we) begin
            ie_q   <= stat_ie_in;
            mode_q <= irq_mode_e'(stat_mode_in);
         end
         // A period end wins over a clearing write in the same cycle.
         if (period_end) begin
            flag_q <= 1'b1;
         end else if (stat_we && !stat_flag_in) begin
            flag_q <= 1'b0;
         end
      end
   end

   tmr_tick_sel #(
      .NUM_SRC (NUM_SRC)
   ) u_sel (
      .src_tick (src_tick),
      .sel      (sel_q),
      .tick     (tick)
   );

   tmr_down_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .tick       (tick),
      .reload_we  (reload_we),
      .reload_in  (reload_in),
      .count      (count),
      .reload     (reload_q),
      .period_end (period_end)
   );

   // The pulse width depends on the source and on whether n is 1.
   always_comb begin
      case (sel_q)
         SEL_W'(0): width = (reload_q == CNT_W'(1)) ? PW_W'(PW_FAST_ONE) : PW_W'(PW_FAST_MANY);
         SEL_W'(1): width = (reload_q == CNT_W'(1)) ? PW_W'(PW_MID_ONE)  : PW_W'(PW_MID_MANY);
         default:   width = PW_W'(PW_SLOW);
      endcase
   end

   tmr_pulse_gen #(
      .PW_W (PW_W)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (period_end),
      .width    (width),
      .ref_tick (ref_tick),
      .active   (pulse_active)
   );

   assign irq_n = !(ie_q && ((mode_q == IRQ_PULSE) ? pulse_active : flag_q));
   assign flag  = flag_q;

endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_q,
   input logic             ie_q,
   input logic             mode_q,
   input logic [CNT_W-1:0] reload_q,
   input logic             reload_we,
   input logic             stat_we,
   input logic             stat_flag_in,
   input logic             flag,
   input logic             irq_n,
   input logic [CNT_W-1:0] count
);

   AST_END_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(count) == CNT_W'(1)));                          // R3

   AST_END_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (count == $past(reload_q)));                           // R3

   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && reload_q == '0 && !reload_we) |=> ($stable(count) && !$rose(flag))); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(stat_we && !stat_flag_in)) |=> flag);                       // R5

   AST_IE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> irq_n);                                                      // R6

   AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && mode_q && ie_q) |-> !irq_n);                           // R7

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !reload_we) |=> $stable(count));                            // R10

endmodule

bind tmr_countdown tmr_countdown_chk #(
   .CNT_W (CNT_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_q        (run_q),
   .ie_q         (ie_q),
   .mode_q       (mode_q),
   .reload_q     (reload_q),
   .reload_we    (reload_we),
   .stat_we      (stat_we),
   .stat_flag_in (stat_flag_in),
   .flag         (flag),
   .irq_n        (irq_n),
   .count        (count)
);

// File: tb/tmr_countdown_tb_top.sv
module tmr_countdown_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src_tick = '0;
   logic       ref_tick = 1'b0;
   logic       run_we = 1'b0, run_in = 1'b0;
   logic       sel_we = 1'b0;
   logic [1:0] sel_in = '0;
   logic       reload_we = 1'b0;
   logic [7:0] reload_in = '0;
   logic       stat_we = 1'b0, stat_flag_in = 1'b1, stat_ie_in = 1'b0, stat_mode_in = 1'b0;
   logic       irq_n, flag;
   logic [7:0] count;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = !clk;

   tmr_countdown dut_i (
      .clk (clk), .rst_n (rst_n), .src_tick (src_tick), .ref_tick (ref_tick),
      .run_we (run_we), .run_in (run_in), .sel_we (sel_we), .sel_in (sel_in),
      .reload_we (reload_we), .reload_in (reload_in),
      .stat_we (stat_we), .stat_flag_in (stat_flag_in), .stat_ie_in (stat_ie_in),
      .stat_mode_in (stat_mode_in),
      .irq_n (irq_n), .flag (flag), .count (count)
   );

   typedef struct packed {
      logic [1:0] sel;
      logic [7:0] n;
      logic [7:0] k;
      logic [7:0] cnt;
      logic       flg;
   } vec_t;

   // {source, reload n, ticks applied, expected count, expected flag}
   localparam vec_t VECS [8] = '{
      '{2'd0, 8'd3,   8'd1,  8'd2,   1'b0},
      '{2'd0, 8'd3,   8'd3,  8'd3,   1'b1},
      '{2'd1, 8'd5,   8'd7,  8'd3,   1'b1},
      '{2'd2, 8'd1,   8'd4,  8'd1,   1'b1},
      '{2'd3, 8'd200, 8'd10, 8'd190, 1'b0},
      '{2'd2, 8'd0,   8'd5,  8'd0,   1'b0},
      '{2'd1, 8'd2,   8'd2,  8'd2,   1'b1},
      '{2'd3, 8'd4,   8'd6,  8'd2,   1'b1}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // All drive tasks start and end at a falling clock edge.
   task automatic wr_run(input logic r);
      run_we = 1'b1; run_in = r; @(negedge clk); run_we = 1'b0;
   endtask

   task automatic wr_sel(input logic [1:0] s);
      sel_we = 1'b1; sel_in = s; @(negedge clk); sel_we = 1'b0;
   endtask

   task automatic wr_reload(input logic [7:0] v);
      reload_we = 1'b1; reload_in = v; @(negedge clk); reload_we = 1'b0;
   endtask

   task automatic wr_stat(input logic f, input logic ie, input logic m);
      stat_we = 1'b1; stat_flag_in = f; stat_ie_in = ie; stat_mode_in = m;
      @(negedge clk); stat_we = 1'b0; stat_flag_in = 1'b1;
   endtask

   task automatic src_pulse(input int i);
      src_tick = 4'(1 << i); @(negedge clk); src_tick = '0;
   endtask

   task automatic ref_pulse();
      ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
   endtask

   task automatic setup(input logic [1:0] s, input logic [7:0] n, input logic ie, input logic m);
      wr_run(1'b0);
      wr_sel(s);
      wr_reload(n);
      wr_stat(1'b0, ie, m);
      wr_run(1'b1);
   endtask

   task automatic meas_width(input logic [1:0] s, input logic [7:0] n, input int exp);
      int w;
      setup(s, n, 1'b1, 1'b1);
      for (int i = 0; i < n; i++) src_pulse(int'(s));
      chk("R7 irq low at period end", int'(irq_n), 0);
      chk("R7 flag set with pulse", int'(flag), 1);
      w = 0;
      while (irq_n == 1'b0 && w < 300) begin
         ref_pulse();
         w++;
      end
      chk($sformatf("R8 width src%0d n%0d", s, n), w, exp);
      chk("R7 irq released while flag set", int'(irq_n) * 2 + int'(flag), 3);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", int'(count), 0);
      chk("R1 flag", int'(flag), 0);
      chk("R1 irq_n", int'(irq_n), 1);
      wr_reload(8'd2);
      chk("R1 stopped load", int'(count), 2);
      wr_run(1'b1);
      src_pulse(0); src_pulse(1); src_pulse(2);
      chk("R1 default select ignores 0..2", int'(count), 2);
      src_pulse(3);
      chk("R1 default select is 3", int'(count), 1);

      // Vector table walk
      foreach (VECS[v]) begin
         setup(VECS[v].sel, VECS[v].n, 1'b0, 1'b0);
         chk("R9 stopped load", int'(count), int'(VECS[v].n));
         for (int t = 0; t < int'(VECS[v].k); t++) begin
            src_pulse(int'(VECS[v].sel));
            src_pulse((int'(VECS[v].sel) + 1) % 4);
         end
         chk($sformatf("R3 R4 count vec%0d", v), int'(count), int'(VECS[v].cnt));
         chk($sformatf("R5 flag vec%0d", v), int'(flag), int'(VECS[v].flg));
      end

      // R2 all other sources ignored
      setup(2'd1, 8'd5, 1'b0, 1'b0);
      src_pulse(0); src_pulse(2); src_pulse(3);
      chk("R2 other sources", int'(count), 5);
      src_pulse(1);
      chk("R2 selected source", int'(count), 4);

      // R5 / R6 level mode
      setup(2'd0, 8'd2, 1'b1, 1'b0);
      chk("R6 no flag no irq", int'(irq_n), 1);
      src_pulse(0); src_pulse(0);
      chk("R5 flag set", int'(flag), 1);
      chk("R6 irq level", int'(irq_n), 0);
      wr_stat(1'b1, 1'b1, 1'b0);
      chk("R5 write 1 keeps flag", int'(flag), 1);
      wr_stat(1'b1, 1'b0, 1'b0);
      chk("R6 ie off releases irq", int'(irq_n), 1);
      wr_stat(1'b0, 1'b1, 1'b0);
      chk("R5 write 0 clears", int'(flag), 0);
      chk("R6 irq follows flag", int'(irq_n), 1);
      src_pulse(0);
      stat_we = 1'b1; stat_flag_in = 1'b0; stat_ie_in = 1'b1; stat_mode_in = 1'b0;
      src_tick = 4'b0001;
      @(negedge clk);
      stat_we = 1'b0; stat_flag_in = 1'b1; src_tick = '0;
      chk("R5 set wins over clear", int'(flag), 1);

      // R7 pulse mode with ie off
      setup(2'd0, 8'd1, 1'b0, 1'b1);
      src_pulse(0);
      chk("R7 ie off no pulse", int'(irq_n), 1);

      // R8 widths
      meas_width(2'd0, 8'd1, 1);
      meas_width(2'd0, 8'd3, 2);
      meas_width(2'd1, 8'd1, 64);
      meas_width(2'd1, 8'd2, 128);
      meas_width(2'd2, 8'd1, 128);
      meas_width(2'd3, 8'd2, 128);

      // R9 reload write while running
      setup(2'd0, 8'd3, 1'b0, 1'b0);
      src_pulse(0);
      wr_reload(8'd5);
      chk("R9 running write deferred", int'(count), 2);
      src_pulse(0); src_pulse(0);
      chk("R9 new value at reload", int'(count), 5);

      // R10 stopped counter holds
      wr_run(1'b0);
      src_pulse(0); src_pulse(0);
      chk("R10 stopped holds", int'(count), 5);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule